// File: doc/BRIEF.md
# UART Transmit Queue with Threshold Flag

This block is the byte queue that sits in front of a UART transmit shift register. It holds up to sixteen bytes in first-in first-out order. Bytes arrive from two sources, a processor register write and a DMA write, and leave one at a time when the shift register asks for the next byte. The current fill level is always visible on an output.

A sticky status flag tells software or a DMA engine that the queue has room for more data. The flag rises when a byte leaves the queue and the remaining level is at or below a threshold. A 2-bit select input picks that threshold. The flag falls in two cases only. In the first, software has read it as 1, later writes 0 to it, and the level then exceeds the threshold. In the second, a DMA write lifts the level above the threshold. Both resets leave the flag at 1 and the queue empty.

Top module: `uart_txq_trig`

## Requirements
- R1: The queue holds up to 16 bytes. `level_o` reports the count from 0 to 16. `pop_valid` is high exactly when the count is nonzero. Bytes leave in the order they were accepted, and a pop on an empty queue has no effect.
- R2: A write from either source that arrives while the count is 16 is discarded. A pop in the same cycle does not make room for it.
- R3: When a pop leaves the resulting count at or below the threshold, the flag reads 1 from the next cycle on.
- R4: The threshold follows `trig_sel`: 2'b00 gives 8, 2'b01 gives 4, 2'b10 gives 2, 2'b11 gives 1.
- R5: A `cpu_flag_rd` strobe while the flag is 1 arms a clear. A later `cpu_flag_wr` with `cpu_flag_wdat` = 0 then clears the flag, but only if the count after that cycle exceeds the threshold. A refused clear leaves the flag at 1.
- R6: A flag write of 0 with no armed read since the flag last rose leaves the flag at 1. Processor data writes never clear the flag on their own.
- R7: An accepted DMA write that leaves the count above the threshold clears the flag in the next cycle. No prior read is needed.
- R8: A push and a pop accepted in the same cycle leave the count unchanged, and the flag is judged on that count.
- R9: An asynchronous power-on reset (`rst_n` low) and a synchronous manual reset (`soft_rst` high) each empty the queue, set the flag to 1 and disarm the clear.
- R10: When processor and DMA write in the same cycle, the processor byte is taken and the DMA byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous manual reset, active high |
| trig_sel | input | 2 | Threshold select |
| cpu_wr_en | input | 1 | Processor data write strobe |
| cpu_wr_data | input | 8 | Processor data byte |
| cpu_flag_rd | input | 1 | Processor read strobe of the flag |
| cpu_flag_wr | input | 1 | Processor write strobe of the flag |
| cpu_flag_wdat | input | 1 | Value written to the flag |
| dma_wr_en | input | 1 | DMA data write strobe |
| dma_wr_data | input | 8 | DMA data byte |
| pop_req | input | 1 | Shift register takes the head byte |
| pop_data | output | 8 | Head byte of the queue |
| pop_valid | output | 1 | Queue is not empty |
| level_o | output | 5 | Current byte count |
| flag_o | output | 1 | Sticky room-available flag |

## Verification
Bytes pass through the scoreboard under four patterns: processor-only fills, DMA-only fills, a push and a pop in the same cycle, and writes from both sources in the same cycle. Together these check ordering, the priority between the sources and the steady level. The flag is driven across its threshold under all four select codes. This separates set-by-pop from clear-by-DMA and shows that each threshold value is decoded on its own. Handshake patterns compare a write of 0 with and without a prior read, and a clear with the level above and at the threshold. Full-queue writes from each source, and a manual reset in mid-stream, cover the discard and restart behaviour.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_CPU  = 2'd1,
      SRC_DMA  = 2'd2
   } txq_src_e;

   // Threshold for a select code: the depth halved (code+1) times.
   function automatic int unsigned trig_from_depth(input int unsigned depth,
                                                   input int unsigned code);
      return depth >> (code + 1);
   endfunction
endpackage

// File: rtl/txq_trig_decode.sv
module txq_trig_decode
   import uart_txq_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int SEL_W     = 2,
   parameter bit SCALE_DEP = 1'b1,
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CW-1:0]    trig
);
   localparam int NCODE = 1 << SEL_W;

   logic [CW-1:0] table_q [NCODE];

   generate
      for (genvar c = 0; c < NCODE; c++) begin : g_code
         if (SCALE_DEP) begin : g_scaled
            assign table_q[c] = CW'(trig_from_depth(DEPTH, c));
         end else begin : g_fixed
            assign table_q[c] = CW'(8 >> c);
         end
      end
   endgenerate

   assign trig = table_q[sel];
endmodule

// File: rtl/txq_src_arb.sv
module txq_src_arb
   import uart_txq_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          cpu_en,
   input  logic [DW-1:0] cpu_data,
   input  logic          dma_en,
   input  logic [DW-1:0] dma_data,
   output txq_src_e      src,
   output logic [DW-1:0] data
);
   always_comb begin
      src  = SRC_NONE;
      data = '0;
      if (cpu_en) begin
         src  = SRC_CPU;
         data = cpu_data;
      end else if (dma_en) begin
         src  = SRC_DMA;
         data = dma_data;
      end
   end
endmodule

// File: rtl/txq_store.sv
module txq_store #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push_req,
   input  logic [DW-1:0] push_data,
   input  logic          pop_req,
   output logic          push_ok,
   output logic          pop_ok,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic [CW-1:0] count_nxt
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          full, empty;

   assign full      = (count == CW'(DEPTH));
   assign empty     = (count == '0);
   assign push_ok   = push_req && !full;
   assign pop_ok    = pop_req && !empty;
   assign count_nxt = count + CW'(push_ok) - CW'(pop_ok);
   assign head      = mem[rptr];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_slot
         always_ff @(posedge clk) begin
            if (push_ok && wptr == AW'(e)) mem[e] <= push_data;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         count <= count_nxt;
      end
   end
endmodule

// File: rtl/txq_flag_ctl.sv
module txq_flag_ctl #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [CW-1:0] count_nxt,
   input  logic [CW-1:0] trig,
   input  logic          pop_ok,
   input  logic          dma_ok,
   input  logic          rd_stb,
   input  logic          wr_stb,
   input  logic          wr_bit,
   output logic          flag
);
   logic armed;
   logic above, set_ev, sw_clr, dma_clr;

   assign above   = (count_nxt > trig);
   assign set_ev  = pop_ok && !above;
   assign sw_clr  = wr_stb && !wr_bit && armed && above;
   assign dma_clr = dma_ok && above;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b1;
         armed <= 1'b0;
      end else if (clr) begin
         flag  <= 1'b1;
         armed <= 1'b0;
      end else if (set_ev) begin
         flag  <= 1'b1;
         armed <= 1'b0;
      end else if (sw_clr || dma_clr) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else if (rd_stb && flag) begin
         armed <= 1'b1;
      end
   end
endmodule

// File: rtl/uart_txq_trig.sv
module uart_txq_trig
   import uart_txq_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int DW        = 8,
   parameter int SEL_W     = 2,
   parameter bit SCALE_DEP = 1'b1,
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic [SEL_W-1:0] trig_sel,
   input  logic             cpu_wr_en,
   input  logic [DW-1:0]    cpu_wr_data,
   input  logic             cpu_flag_rd,
   input  logic             cpu_flag_wr,
   input  logic             cpu_flag_wdat,
   input  logic             dma_wr_en,
   input  logic [DW-1:0]    dma_wr_data,
   input  logic             pop_req,
   output logic [DW-1:0]    pop_data,
   output logic             pop_valid,
   output logic [CW-1:0]    level_o,
   output logic             flag_o
);
   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
         $error("DEPTH must be a power of two");
      end
      if ((DEPTH >> (1 << SEL_W)) < 1) begin : g_bad_depth
         $error("DEPTH too small for the largest select code");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
   endgenerate

   txq_src_e      src;
   logic [DW-1:0] push_data;
   logic          push_ok, pop_ok;
   logic [CW-1:0] count, count_nxt, trig;

   txq_trig_decode #(.DEPTH(DEPTH), .SEL_W(SEL_W), .SCALE_DEP(SCALE_DEP)) u_trig (
      .sel  (trig_sel),
      .trig (trig)
   );

   txq_src_arb #(.DW(DW)) u_arb (
      .cpu_en   (cpu_wr_en),
      .cpu_data (cpu_wr_data),
      .dma_en   (dma_wr_en),
      .dma_data (dma_wr_data),
      .src      (src),
      .data     (push_data)
   );

   txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (soft_rst),
      .push_req  (src != SRC_NONE),
      .push_data (push_data),
      .pop_req   (pop_req),
      .push_ok   (push_ok),
      .pop_ok    (pop_ok),
      .head      (pop_data),
      .count     (count),
      .count_nxt (count_nxt)
   );

   txq_flag_ctl #(.CW(CW)) u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (soft_rst),
      .count_nxt (count_nxt),
      .trig      (trig),
      .pop_ok    (pop_ok),
      .dma_ok    (push_ok && src == SRC_DMA),
      .rd_stb    (cpu_flag_rd),
      .wr_stb    (cpu_flag_wr),
      .wr_bit    (cpu_flag_wdat),
      .flag      (flag_o)
   );

   assign level_o   = count;
   assign pop_valid = (count != '0);
endmodule

// File: rtl/uart_txq_trig_chk.sv
module uart_txq_trig_chk #(
   parameter int DEPTH = 16,
   parameter int SEL_W = 2,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic [SEL_W-1:0] trig_sel,
   input logic             cpu_wr_en,
   input logic             cpu_flag_wr,
   input logic             cpu_flag_wdat,
   input logic             dma_wr_en,
   input logic             pop_req,
   input logic             pop_valid,
   input logic [CW-1:0]    level_o,
   input logic             flag_o
);
   logic [CW-1:0] thr;
   logic          any_wr;
   assign thr    = CW'(DEPTH >> (int'(trig_sel) + 1));
   assign any_wr = cpu_wr_en || dma_wr_en;

   assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      level_o <= CW'(DEPTH) && pop_valid == (level_o != '0));

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && level_o == CW'(DEPTH) && !pop_req && any_wr) |=> level_o == CW'(DEPTH));

   assert_pop_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && pop_req && level_o != '0 && !any_wr && (level_o - 1'b1) <= thr) |=> flag_o);

   assert_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> ($past((cpu_flag_wr && !cpu_flag_wdat) || dma_wr_en) && level_o > $past(thr)));

   assert_steady_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && pop_req && level_o != '0 && level_o != CW'(DEPTH) && any_wr) |=> $stable(level_o));

   assert_manual_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (flag_o && level_o == '0));
endmodule

bind uart_txq_trig uart_txq_trig_chk #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .soft_rst      (soft_rst),
   .trig_sel      (trig_sel),
   .cpu_wr_en     (cpu_wr_en),
   .cpu_flag_wr   (cpu_flag_wr),
   .cpu_flag_wdat (cpu_flag_wdat),
   .dma_wr_en     (dma_wr_en),
   .pop_req       (pop_req),
   .pop_valid     (pop_valid),
   .level_o       (level_o),
   .flag_o        (flag_o)
);

// File: tb/tb_uart_txq_trig.sv
`timescale 1ns/1ps
module tb_uart_txq_trig;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0, soft_rst = 1'b0;
   logic [1:0] trig_sel = 2'b00;
   logic       cpu_wr_en = 0, cpu_flag_rd = 0, cpu_flag_wr = 0, cpu_flag_wdat = 0;
   logic [7:0] cpu_wr_data = 0, dma_wr_data = 0;
   logic       dma_wr_en = 0, pop_req = 0;
   logic [7:0] pop_data;
   logic       pop_valid, flag_o;
   logic [4:0] level_o;

   int checks = 0, errors = 0, exp_lvl = 0;
   logic [7:0] sb[$];

   always #10 clk = ~clk;

   uart_txq_trig dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .trig_sel(trig_sel),
      .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
      .cpu_flag_rd(cpu_flag_rd), .cpu_flag_wr(cpu_flag_wr), .cpu_flag_wdat(cpu_flag_wdat),
      .dma_wr_en(dma_wr_en), .dma_wr_data(dma_wr_data),
      .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
      .level_o(level_o), .flag_o(flag_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: compares each delivered byte with the scoreboard head (R1).
   always begin
      @(negedge clk);
      #5;
      if (pop_req && pop_valid) begin
         if (sb.size() == 0) chk("R1 unexpected byte", pop_data, -1);
         else chk("R1 order", pop_data, sb.pop_front());
      end
   end

   task automatic step();
      @(negedge clk);
      cpu_wr_en = 0; dma_wr_en = 0; pop_req = 0;
      cpu_flag_rd = 0; cpu_flag_wr = 0; soft_rst = 0;
   endtask

   task automatic cpu_push(input logic [7:0] b);
      cpu_wr_en = 1; cpu_wr_data = b;
      if (exp_lvl < 16) begin sb.push_back(b); exp_lvl++; end
      step();
   endtask

   task automatic dma_push(input logic [7:0] b);
      dma_wr_en = 1; dma_wr_data = b;
      if (exp_lvl < 16) begin sb.push_back(b); exp_lvl++; end
      step();
   endtask

   task automatic pop1();
      pop_req = 1;
      if (exp_lvl > 0) exp_lvl--;
      step();
   endtask

   task automatic rd_flag();
      cpu_flag_rd = 1;
      step();
   endtask

   task automatic wr_flag0();
      cpu_flag_wr = 1; cpu_flag_wdat = 0;
      step();
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R9 reset flag", flag_o, 1);
      chk("R9 reset level", level_o, 0);
      chk("R1 reset valid", pop_valid, 0);

      pop1();
      chk("R1 empty pop", level_o, 0);

      for (int i = 0; i < 10; i++) cpu_push(8'h10 + 8'(i));
      chk("R1 level 10", level_o, 10);
      chk("R6 cpu data no clear", flag_o, 1);
      wr_flag0();
      chk("R6 unarmed write", flag_o, 1);
      rd_flag(); wr_flag0();
      chk("R5 armed clear", flag_o, 0);

      pop1();
      chk("R3 above trig", flag_o, 0);
      pop1();
      chk("R3 level 8 sets", flag_o, 1);
      rd_flag(); wr_flag0();
      chk("R5 clear refused at trig", flag_o, 1);
      dma_push(8'hD0);
      chk("R7 dma clear", flag_o, 0);
      chk("R7 level", level_o, 9);

      for (int i = 0; i < 7; i++) cpu_push(8'h40 + 8'(i));
      chk("R1 full", level_o, 16);
      cpu_push(8'hEE);
      chk("R2 cpu drop", level_o, 16);
      dma_push(8'hEF);
      chk("R2 dma drop", level_o, 16);

      cpu_wr_en = 1; cpu_wr_data = 8'hEC; pop_req = 1; exp_lvl--;
      step();
      chk("R2 pop frees no room", level_o, 15);

      cpu_wr_en = 1; cpu_wr_data = 8'h77; pop_req = 1; sb.push_back(8'h77);
      step();
      chk("R8 steady level", level_o, 15);
      chk("R8 flag", flag_o, 0);

      cpu_wr_en = 1; cpu_wr_data = 8'hA1; dma_wr_en = 1; dma_wr_data = 8'hB1;
      sb.push_back(8'hA1); exp_lvl++;
      step();
      chk("R10 one taken", level_o, 16);

      trig_sel = 2'b11;
      while (exp_lvl > 2) pop1();
      chk("R4 code 11 above", flag_o, 0);
      pop1();
      chk("R4 code 11 trig 1", flag_o, 1);
      pop1();
      chk("R1 drained", pop_valid, 0);
      chk("R1 scoreboard empty", sb.size(), 0);

      trig_sel = 2'b10;
      dma_push(8'h01); dma_push(8'h02);
      chk("R4 code 10 at trig", flag_o, 1);
      dma_push(8'h03);
      chk("R4 code 10 trig 2", flag_o, 0);
      pop1();
      chk("R3 code 10 set", flag_o, 1);
      pop1(); pop1();

      trig_sel = 2'b01;
      for (int i = 0; i < 4; i++) dma_push(8'h60 + 8'(i));
      chk("R4 code 01 at trig", flag_o, 1);
      dma_push(8'h64);
      chk("R4 code 01 trig 4", flag_o, 0);

      soft_rst = 1;
      sb.delete(); exp_lvl = 0;
      step();
      chk("R9 manual flag", flag_o, 1);
      chk("R9 manual level", level_o, 0);
      chk("R9 manual valid", pop_valid, 0);

      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule